// File: doc/BRIEF.md
# Pulse-Density DAC Modulator with Return-to-Zero Encoding

This block turns an unsigned code into a one-bit pulse-density stream. After an external low-pass filter, the DC level of the stream follows the code, so the stream can set a 4–20 mA loop current. A first-order error-feedback accumulator makes one output bit every bit period. The bit is the carry out of adding the active code to the held residue. The stream only ever switches between logic 0 and logic 1, and the filter's bandwidth of about 10 Hz means the modulator is heavily oversampled.

A strobe captures three things together: a new code, a resolution select (full 16-bit or 14-bit) and an output encoding select. They take effect at the next bit-period boundary. In return-to-zero encoding, which is the state after reset, each 1 bit becomes a pulse that rises and falls inside its own period. Every 1 bit therefore carries exactly one rising and one falling edge, at the cost of half the output range. In non-return-to-zero encoding each bit is held for its whole period.

Top module: `dens_dac`

## Requirements
- R1: While reset is low and after it is released, dac_o is 0. The encoding is return-to-zero, the resolution is 16-bit, the pending code is 0 and the residue is 0, so without a load dac_o stays 0.
- R2: A bit period is two clock cycles. At the end of each period the 16-bit residue and the 16-bit effective code are added into a 17-bit sum. Bit 16 of the sum becomes the bit for the next period, and bits 15:0 become the new residue.
- R3: Starting from a zero residue, the number of 1 bits over P periods is floor(P*code/65536). Code 32768 gives half density.
- R4: With ld_nrz = 0 (return-to-zero), a 1 bit drives dac_o high in the first cycle of its period and low in the second. A 0 bit keeps dac_o low in both cycles.
- R5: With ld_nrz = 1 (non-return-to-zero), dac_o equals the bit in both cycles of its period.
- R6: With ld_narrow = 1, the effective code is ld_code[13:0] shifted left by 2 bits, and ld_code[15:14] are ignored. With ld_narrow = 0, the effective code is ld_code[15:0].
- R7: ld_stb = 1 at a rising edge captures ld_code, ld_narrow and ld_nrz. The capture is used at the first period boundary after that edge. A strobe at a boundary edge is used at the boundary that follows.
- R8: While ld_stb = 0, changes on ld_code, ld_narrow and ld_nrz have no effect on dac_o.
- R9: Full-scale code 65535 gives a 1 in every period except one in 65536. Code 0 never gives a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | Load strobe for code and modes |
| ld_code | input | CODE_W (16) | Unsigned code |
| ld_narrow | input | 1 | 1 selects 14-bit, left-aligned code |
| ld_nrz | input | 1 | 1 selects non-return-to-zero, 0 return-to-zero |
| dac_o | output | 1 | Pulse-density output |

## Verification
A strobe is sampled at a rising edge. Its values are used at the first later edge that closes a period, which is one or two edges after the strobe. dac_o is registered, so the bit made at that boundary edge appears right after it and lasts two cycles. The bench models this timing cycle by cycle at each rising edge and queues one expected dac_o value for the following cycle. It compares that value with dac_o in the middle of the cycle and flushes the queue whenever reset is asserted. Density checks count high cycles over whole windows of periods, with a tolerance of one bit for the uncertain edge of the window.

// File: rtl/dens_dac_pkg.sv
package dens_dac_pkg;
  typedef enum logic {ENC_RTZ = 1'b0, ENC_NRZ = 1'b1} enc_e;
  typedef enum logic {RES_WIDE = 1'b0, RES_NARROW = 1'b1} res_e;
endpackage

// File: rtl/dens_dac_phase.sv
module dens_dac_phase (
  input  logic clk,
  input  logic rst_n,
  output logic ph_q,
  output logic bnd
);
  logic ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // second cycle of a period closes it
  assign bnd = ph_q;
endmodule

// File: rtl/dens_dac_hold.sv
module dens_dac_hold #(
  parameter int CODE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_stb,
  input  logic [CODE_W-1:0]         ld_code,
  input  logic                      ld_narrow,
  input  logic                      ld_nrz,
  output logic [CODE_W-1:0]         pend_code,
  output dens_dac_pkg::res_e        pend_res,
  output dens_dac_pkg::enc_e        pend_enc
);
  import dens_dac_pkg::*;

  logic [CODE_W-1:0] code_d;
  res_e              res_d;
  enc_e              enc_d;

  always_comb begin
    code_d = pend_code;
    res_d  = pend_res;
    enc_d  = pend_enc;
    if (ld_stb) begin
      code_d = ld_code;
      res_d  = ld_narrow ? RES_NARROW : RES_WIDE;
      enc_d  = ld_nrz ? ENC_NRZ : ENC_RTZ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code <= '0;
      pend_res  <= RES_WIDE;
      pend_enc  <= ENC_RTZ;
    end else begin
      pend_code <= code_d;
      pend_res  <= res_d;
      pend_enc  <= enc_d;
    end
  end
endmodule

// File: rtl/dens_dac_accum.sv
module dens_dac_accum #(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bnd,
  input  logic [CODE_W-1:0]   pend_code,
  input  dens_dac_pkg::res_e  pend_res,
  input  dens_dac_pkg::enc_e  pend_enc,
  output logic                bit_q,
  output dens_dac_pkg::enc_e  enc_q,
  output logic                bit_d,
  output dens_dac_pkg::enc_e  enc_d
);
  import dens_dac_pkg::*;

  localparam int SHIFT = CODE_W - NARROW_W;
  localparam int SUM_W = CODE_W + 1;

  logic [CODE_W-1:0] acc_q, acc_d;
  logic [CODE_W-1:0] narrow_val, eff;
  logic [SUM_W-1:0]  sum;

  generate
    if (SHIFT > 0) begin : g_align
      assign narrow_val = {pend_code[NARROW_W-1:0], {SHIFT{1'b0}}};
    end else begin : g_same
      assign narrow_val = pend_code;
    end
  endgenerate

  always_comb begin
    eff   = (pend_res == RES_NARROW) ? narrow_val : pend_code;
    sum   = {1'b0, acc_q} + {1'b0, eff};
    acc_d = acc_q;
    bit_d = bit_q;
    enc_d = enc_q;
    if (bnd) begin
      acc_d = sum[CODE_W-1:0];
      bit_d = sum[CODE_W];
      enc_d = pend_enc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
      enc_q <= ENC_RTZ;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
      enc_q <= enc_d;
    end
  end
endmodule

// File: rtl/dens_dac_shape.sv
module dens_dac_shape (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ph_q,
  input  logic               bit_d,
  input  dens_dac_pkg::enc_e enc_d,
  output logic               dac_o
);
  import dens_dac_pkg::*;

  logic out_d;

  // ph_q = 1 now means the next cycle opens a period
  always_comb begin
    out_d = bit_d & ((enc_d == ENC_NRZ) | ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_o <= 1'b0;
    else        dac_o <= out_d;
  end
endmodule

// File: rtl/dens_dac.sv
module dens_dac #(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [CODE_W-1:0] ld_code,
  input  logic              ld_narrow,
  input  logic              ld_nrz,
  output logic              dac_o
);
  import dens_dac_pkg::*;

  logic              ph_q, bnd;
  logic [CODE_W-1:0] pend_code;
  res_e              pend_res;
  enc_e              pend_enc;
  logic              bit_q, bit_d;
  enc_e              enc_q, enc_d;

  dens_dac_phase u_phase (
    .clk(clk), .rst_n(rst_n), .ph_q(ph_q), .bnd(bnd)
  );

  dens_dac_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_code(ld_code),
    .ld_narrow(ld_narrow), .ld_nrz(ld_nrz),
    .pend_code(pend_code), .pend_res(pend_res), .pend_enc(pend_enc)
  );

  dens_dac_accum #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .bnd(bnd), .pend_code(pend_code),
    .pend_res(pend_res), .pend_enc(pend_enc),
    .bit_q(bit_q), .enc_q(enc_q), .bit_d(bit_d), .enc_d(enc_d)
  );

  dens_dac_shape u_shape (
    .clk(clk), .rst_n(rst_n), .ph_q(ph_q), .bit_d(bit_d), .enc_d(enc_d),
    .dac_o(dac_o)
  );
endmodule

// File: rtl/dens_dac_chk.sv
module dens_dac_chk #(
  parameter int CODE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_stb,
  input logic [CODE_W-1:0]  ld_code,
  input logic               dac_o,
  input logic               ph_q,
  input logic               bit_q,
  input dens_dac_pkg::enc_e enc_q,
  input logic [CODE_W-1:0]  pend_code
);
  import dens_dac_pkg::*;

  // R1: first edge after release sees a quiet output in RTZ encoding
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dac_o && enc_q == ENC_RTZ));

  // R2: the phase alternates every cycle
  p_phase_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph_q != $past(ph_q)));

  // R2: the bit changes only at edges closing a period
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q |=> $stable(bit_q));

  // R4: return-to-zero keeps the second half of every period low
  p_rtz_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_q == ENC_RTZ && ph_q) |-> !dac_o);

  // R5: non-return-to-zero holds the level across the period
  p_nrz_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_q == ENC_NRZ && ph_q) |-> (dac_o == $past(dac_o)));

  // R7: a strobe captures the code
  p_load_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> (pend_code == $past(ld_code)));

  // R8: no strobe, no change of the held code
  p_load_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> $stable(pend_code));
endmodule

bind dens_dac dens_dac_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_code(ld_code),
  .dac_o(dac_o), .ph_q(ph_q), .bit_q(bit_q), .enc_q(enc_q),
  .pend_code(pend_code)
);

// File: tb/sim_dens_dac.sv
module sim_dens_dac;
  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic          clk;
  logic          rst_n;
  logic          ld_stb;
  logic [CW-1:0] ld_code;
  logic          ld_narrow;
  logic          ld_nrz;
  logic          dac_o;

  int    n_run;
  int    n_fail;
  bit    done;
  string cur_req;

  bit    exp_q[$];
  string tag_q[$];

  // model state
  bit          m_ph, m_bit, m_nrz, p_nrz, p_nar;
  int unsigned m_acc, p_code;

  dens_dac #(.CODE_W(CW), .NARROW_W(14)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_code(ld_code),
    .ld_narrow(ld_narrow), .ld_nrz(ld_nrz), .dac_o(dac_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // model from the requirements: predicts dac_o for the cycle after each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_bit = 0; m_nrz = 0; m_acc = 0;
      p_code = 0; p_nar = 0; p_nrz = 0;
    end else begin
      if (m_ph) begin
        int unsigned eff;
        int unsigned s;
        eff   = p_nar ? ((p_code & 32'h3FFF) << 2) : p_code;  // R6
        s     = m_acc + eff;                                  // R2
        m_bit = s[16];
        m_acc = s & 32'hFFFF;
        m_nrz = p_nrz;
      end
      if (ld_stb) begin                                       // R7
        p_code = ld_code;
        p_nar  = ld_narrow;
        p_nrz  = ld_nrz;
      end
      m_ph = ~m_ph;
      exp_q.push_back(m_bit & (m_nrz | ~m_ph));
      if (m_nrz)     tag_q.push_back("R5");
      else if (m_ph) tag_q.push_back("R4");
      else           tag_q.push_back(cur_req);
    end
  end

  // monitor: compare in mid-cycle
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      exp_q.delete();
      tag_q.delete();
    end else if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (dac_o !== e) begin
        n_fail++;
        $display("FAIL %s: dac_o=%0b expected %0b at %0t", t, dac_o, e, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input int tol);
    n_run++;
    if (act > exp + tol || act + tol < exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ld_stb = 1'b0;
    @(negedge clk);
    check("R1", int'(dac_o), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [CW-1:0] c, input logic nar, input logic nrz);
    ld_stb = 1'b1; ld_code = c; ld_narrow = nar; ld_nrz = nrz;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic density(input string req, input logic [CW-1:0] c, input logic nar,
                         input logic nrz, input int p);
    int unsigned eff;
    int          ones;
    int          cnt;
    cur_req = req;
    do_reset();
    load(c, nar, nrz);
    eff  = nar ? ((int'(c) & 32'h3FFF) << 2) : int'(c);
    ones = int'((longint'(p) * longint'(eff)) >> 16);          // R3
    cnt  = 0;
    for (int i = 0; i < 2*p + 2; i++) begin
      @(negedge clk);
      cnt += int'(dac_o);
    end
    if (nrz) check(req, cnt, 2*ones, 2);
    else     check(req, cnt, ones, 1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0; cur_req = "R1";
    rst_n = 1'b0; ld_stb = 1'b0; ld_code = '0; ld_narrow = 1'b0; ld_nrz = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(dac_o), 0, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R1", int'(dac_o), 0, 0);

    density("R3", 16'h8000, 1'b0, 1'b0, 64);   // half scale, RTZ
    density("R4", 16'h4000, 1'b0, 1'b0, 64);   // quarter, RTZ pulses
    density("R5", 16'h8000, 1'b0, 1'b1, 64);   // half scale, NRZ
    density("R6", 16'hE000, 1'b1, 1'b0, 64);   // top bits ignored, eff 0x8000
    density("R6", 16'h3FFF, 1'b1, 1'b1, 64);   // narrow full scale
    density("R9", 16'hFFFF, 1'b0, 1'b1, 128);  // full scale NRZ
    density("R9", 16'h0000, 1'b0, 1'b1, 64);   // zero never high
    density("R3", 16'h1234, 1'b0, 1'b0, 256);

    // R7: strobes in consecutive cycles, both phases
    cur_req = "R7";
    do_reset();
    repeat (5) @(negedge clk);
    load(16'hC000, 1'b0, 1'b1);
    load(16'h2000, 1'b0, 1'b0);
    load(16'hFFFF, 1'b1, 1'b1);
    repeat (7) @(negedge clk);
    load(16'h9000, 1'b0, 1'b0);
    repeat (40) @(negedge clk);

    // R8: inputs moving with no strobe leave a zero code silent
    cur_req = "R8";
    do_reset();
    load(16'h0000, 1'b0, 1'b0);
    begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < 60; i++) begin
        ld_code = 16'hFFFF - 16'(i * 97); ld_nrz = i[0]; ld_narrow = i[1];
        @(negedge clk);
        cnt += int'(dac_o);
      end
      check("R8", cnt, 0, 0);
    end
    repeat (4) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule